// File: doc/BRIEF.md
# Channel Matrix Register File with Row and Column Read

This block keeps the channel matrix of a multi-antenna receiver close to a four-input compute array. The matrix is stored as an 8-by-4 grid of complex elements, sized for the largest antenna setup. Next to it sit an 8-entry received-vector bank and an 8-entry bank of constants. Every element has a 22-bit real part and a 22-bit imaginary part.

A host loads one complex element per cycle through a write port. A read command selects one bank and a read shape. In a row read, all four elements of one matrix row appear together on the four output lanes. In a column read, one matrix column is presented in two halves, because the output is only four lanes wide. The received vector and the constants are always presented as column halves. The read result is registered and appears one cycle after the command, together with a valid flag.

Top module: `chan_regfile`

## Requirements
- R1: After reset, `rd_valid` is 0 and both data buses are 0, and every stored element reads back as zero.
- R2: A matrix row read has target code 0 and `rd_mode`=0. It places element (row `rd_idx`, column p) on lane p, for lanes 0 to 3, one cycle after the command, with `rd_valid`=1. Lane p occupies bits [22p+21:22p] of `rd_re` and of `rd_im`.
- R3: A matrix column read has target code 0 and `rd_mode`=1. It places element (row 4·`rd_half`+p, column `rd_idx`) on lane p. So `rd_half`=0 returns rows 0 to 3, and `rd_half`=1 returns rows 4 to 7.
- R4: A read with target code 1 (received vector) or 2 (constants) places entry 4·`rd_half`+p on lane p. For these targets `rd_mode` and `rd_idx` have no effect.
- R5: A matrix row read with `rd_idx` above 7, or a matrix column read with `rd_idx` above 3, returns zeros on all lanes, with `rd_valid`=1.
- R6: A write with target code 0 stores the element at (`wr_row`, `wr_col`). A write with code 1 or 2 stores entry `wr_row` and ignores `wr_col`. The following writes change nothing: a matrix row above 7, a matrix column above 3, a vector entry above 7, or target code 3.
- R7: When a write and a read touch the same element in the same cycle, the read returns the value held before the write. The new value is returned by the next read.
- R8: In a cycle with `rd_en`=0, `rd_valid` is 0 in the following cycle and both data buses keep their previous values.
- R9: A read with target code 3 returns zeros on all lanes, with `rd_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: 0 matrix, 1 received vector, 2 constants, 3 none |
| wr_row | input | 4 | Matrix row or vector entry to write |
| wr_col | input | 4 | Matrix column to write |
| wr_re | input | 22 | Real part of the written element |
| wr_im | input | 22 | Imaginary part of the written element |
| rd_en | input | 1 | Read command strobe |
| rd_tgt | input | 2 | Read target, same codes as `wr_tgt` |
| rd_mode | input | 1 | Read shape: 0 row, 1 column (matrix only) |
| rd_idx | input | 4 | Row or column index of a matrix read |
| rd_half | input | 1 | Column half: 0 entries 0-3, 1 entries 4-7 |
| rd_valid | output | 1 | Registered read result is valid |
| rd_re | output | 88 | Real parts of the four lanes, lane p at bits 22p+21:22p |
| rd_im | output | 88 | Imaginary parts of the four lanes, same packing |

## Verification
The two functions that can meet in one cycle are a host write and a read of the same element. The bench provokes this in two cases. In the first, it writes a new value into one matrix cell while a row read selects that cell's row. In the second, it writes a received-vector entry while a column-half read covers that entry. The scoreboard expects the pre-write value from the colliding read and the new value from the read that follows. It builds that expectation by computing the read result from its reference model before applying the write to that model.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    parameter int unsigned ELEM_W  = 22;
    parameter int unsigned NLANE   = 4;
    parameter int unsigned H_COLS  = NLANE;
    parameter int unsigned H_ROWS  = 2 * NLANE;
    parameter int unsigned VEC_LEN = H_ROWS;
    parameter int unsigned IDX_W   = 4;

    typedef struct packed {
        logic signed [ELEM_W-1:0] re;
        logic signed [ELEM_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        TGT_H    = 2'd0,
        TGT_Y    = 2'd1,
        TGT_K    = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic                    vld;
        cplx_t [NLANE-1:0]       lane;
    } rd_state_t;

endpackage

// File: rtl/chreg_bank.sv
module chreg_bank
    import chreg_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int IW   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IW-1:0]                 wrow,
    input  logic [IW-1:0]                 wcol,
    input  cplx_t                         wdata,
    output cplx_t [ROWS-1:0][COLS-1:0]    cells_o
);

    cplx_t [ROWS-1:0][COLS-1:0] mem_d, mem_q;

    // Only an exact in-range address match updates a cell
    always_comb begin
        mem_d = mem_q;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (we && int'(wrow) == r && int'(wcol) == c)
                    mem_d[r][c] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign cells_o = mem_q;

    // R6
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(wrow) < ROWS && int'(wcol) < COLS)
        |=> cells_o[$past(wrow)][$past(wcol)] == $past(wdata));

    // R6
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || int'(wrow) >= ROWS || int'(wcol) >= COLS) |=> $stable(cells_o));

endmodule

// File: rtl/chreg_rdsel.sv
module chreg_rdsel
    import chreg_pkg::*;
(
    input  cplx_t [H_ROWS-1:0][H_COLS-1:0]  h_i,
    input  cplx_t [VEC_LEN-1:0][0:0]        y_i,
    input  cplx_t [VEC_LEN-1:0][0:0]        k_i,
    input  tgt_e                            tgt,
    input  logic                            mode,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            half,
    output cplx_t [NLANE-1:0]               lane_o
);

    for (genvar p = 0; p < NLANE; p++) begin : g_lane
        cplx_t lane_v;
        always_comb begin
            lane_v = '0;
            unique case (tgt)
                TGT_H: begin
                    if (!mode) begin
                        if (int'(idx) < H_ROWS) lane_v = h_i[idx][p];
                    end else begin
                        if (int'(idx) < H_COLS) lane_v = h_i[int'(half) * NLANE + p][idx];
                    end
                end
                TGT_Y:   lane_v = y_i[int'(half) * NLANE + p][0];
                TGT_K:   lane_v = k_i[int'(half) * NLANE + p][0];
                default: lane_v = '0;
            endcase
        end
        assign lane_o[p] = lane_v;
    end

endmodule

// File: rtl/chan_regfile.sv
module chan_regfile
    import chreg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_tgt,
    input  logic [IDX_W-1:0]          wr_row,
    input  logic [IDX_W-1:0]          wr_col,
    input  logic [ELEM_W-1:0]         wr_re,
    input  logic [ELEM_W-1:0]         wr_im,
    input  logic                      rd_en,
    input  logic [1:0]                rd_tgt,
    input  logic                      rd_mode,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      rd_half,
    output logic                      rd_valid,
    output logic [NLANE*ELEM_W-1:0]   rd_re,
    output logic [NLANE*ELEM_W-1:0]   rd_im
);

    cplx_t                           wdata;
    cplx_t [H_ROWS-1:0][H_COLS-1:0]  h_cells;
    cplx_t [VEC_LEN-1:0][0:0]        y_cells, k_cells;
    cplx_t [NLANE-1:0]               sel_lane;
    rd_state_t                       st_d, st_q;
    logic                            we_h, we_y, we_k;

    assign wdata = '{re: wr_re, im: wr_im};
    assign we_h  = wr_en && (tgt_e'(wr_tgt) == TGT_H);
    assign we_y  = wr_en && (tgt_e'(wr_tgt) == TGT_Y);
    assign we_k  = wr_en && (tgt_e'(wr_tgt) == TGT_K);

    chreg_bank #(.ROWS(H_ROWS), .COLS(H_COLS), .IW(IDX_W)) u_hbank (
        .clk(clk), .rst_n(rst_n), .we(we_h), .wrow(wr_row), .wcol(wr_col),
        .wdata(wdata), .cells_o(h_cells)
    );

    chreg_bank #(.ROWS(VEC_LEN), .COLS(1), .IW(IDX_W)) u_ybank (
        .clk(clk), .rst_n(rst_n), .we(we_y), .wrow(wr_row), .wcol('0),
        .wdata(wdata), .cells_o(y_cells)
    );

    chreg_bank #(.ROWS(VEC_LEN), .COLS(1), .IW(IDX_W)) u_kbank (
        .clk(clk), .rst_n(rst_n), .we(we_k), .wrow(wr_row), .wcol('0),
        .wdata(wdata), .cells_o(k_cells)
    );

    chreg_rdsel u_rdsel (
        .h_i(h_cells), .y_i(y_cells), .k_i(k_cells),
        .tgt(tgt_e'(rd_tgt)), .mode(rd_mode), .idx(rd_idx), .half(rd_half),
        .lane_o(sel_lane)
    );

    // Lanes sample the banks before this edge's write lands
    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en) st_d.lane = sel_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.vld;
    for (genvar p = 0; p < NLANE; p++) begin : g_out
        assign rd_re[p*ELEM_W +: ELEM_W] = st_q.lane[p].re;
        assign rd_im[p*ELEM_W +: ELEM_W] = st_q.lane[p].im;
    end

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_re) && $stable(rd_im)));

    // R5
    row_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_tgt == 2'd0 && !rd_mode && int'(rd_idx) >= H_ROWS)
        |=> (rd_re == '0 && rd_im == '0));

    // R5
    col_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_tgt == 2'd0 && rd_mode && int'(rd_idx) >= H_COLS)
        |=> (rd_re == '0 && rd_im == '0));

    // R9
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_tgt == 2'd3) |=> (rd_re == '0 && rd_im == '0));

endmodule

// File: tb/chan_regfile_tb_top.sv
module chan_regfile_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 22;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rd_mode = 1'b0, rd_half = 1'b0;
    logic [1:0] wr_tgt = '0, rd_tgt = '0;
    logic [3:0] wr_row = '0, wr_col = '0, rd_idx = '0;
    logic [W-1:0] wr_re = '0, wr_im = '0;
    logic rd_valid;
    logic [L*W-1:0] rd_re, rd_im;

    always #10 clk = ~clk;

    chan_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_row(wr_row),
        .wr_col(wr_col), .wr_re(wr_re), .wr_im(wr_im), .rd_en(rd_en), .rd_tgt(rd_tgt),
        .rd_mode(rd_mode), .rd_idx(rd_idx), .rd_half(rd_half), .rd_valid(rd_valid),
        .rd_re(rd_re), .rd_im(rd_im)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int mh_re[8][4], mh_im[8][4];
    int my_re[8], my_im[8], mk_re[8], mk_im[8];

    bit           q_v[$];
    logic [L*W-1:0] q_re[$], q_im[$];
    string        q_tag[$];
    logic [L*W-1:0] last_re = '0, last_im = '0;

    function automatic int pv(int t, int r, int c);
        return t * 4096 + r * 64 + c * 7 + 3;
    endfunction

    task automatic expect_read(input int t, input bit m, input int idx, input bit h,
                               output logic [L*W-1:0] er, output logic [L*W-1:0] ei);
        er = '0;
        ei = '0;
        for (int p = 0; p < L; p++) begin
            int vr = 0;
            int vi = 0;
            if (t == 0 && !m && idx < 8) begin
                vr = mh_re[idx][p]; vi = mh_im[idx][p];
            end else if (t == 0 && m && idx < 4) begin
                vr = mh_re[h*4+p][idx]; vi = mh_im[h*4+p][idx];
            end else if (t == 1) begin
                vr = my_re[h*4+p]; vi = my_im[h*4+p];
            end else if (t == 2) begin
                vr = mk_re[h*4+p]; vi = mk_im[h*4+p];
            end
            er[p*W +: W] = vr[W-1:0];
            ei[p*W +: W] = vi[W-1:0];
        end
    endtask

    task automatic cyc(input bit we, input int wt, input int wr, input int wc,
                       input int vre, input int vim,
                       input bit re_, input int rt, input bit rm, input int ri,
                       input bit rh, input string tag);
        logic [L*W-1:0] er, ei;
        @(negedge clk);
        wr_en = we; wr_tgt = wt[1:0]; wr_row = wr[3:0]; wr_col = wc[3:0];
        wr_re = vre[W-1:0]; wr_im = vim[W-1:0];
        rd_en = re_; rd_tgt = rt[1:0]; rd_mode = rm; rd_idx = ri[3:0]; rd_half = rh;
        if (re_) begin
            expect_read(rt, rm, ri, rh, er, ei);
            last_re = er; last_im = ei;
        end
        q_v.push_back(re_); q_re.push_back(last_re); q_im.push_back(last_im);
        q_tag.push_back(tag);
        // model update after the read expectation: old value on collision (R7)
        if (we) begin
            if (wt == 0 && wr < 8 && wc < 4) begin mh_re[wr][wc] = vre; mh_im[wr][wc] = vim; end
            else if (wt == 1 && wr < 8) begin my_re[wr] = vre; my_im[wr] = vim; end
            else if (wt == 2 && wr < 8) begin mk_re[wr] = vre; mk_im[wr] = vim; end
        end
    endtask

    task automatic rd(input int rt, input bit rm, input int ri, input bit rh, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, rt, rm, ri, rh, tag);
    endtask

    task automatic wr(input int wt, input int r, input int c, input int vre, input int vim,
                      input string tag);
        cyc(1, wt, r, c, vre, vim, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: one scoreboard item per driven cycle
    always @(posedge clk) begin
        #5;
        if (q_v.size() > 0) begin
            bit v;
            logic [L*W-1:0] er, ei;
            string tg;
            v = q_v.pop_front(); er = q_re.pop_front(); ei = q_im.pop_front();
            tg = q_tag.pop_front();
            n_checks++;
            if (rd_valid !== v || rd_re !== er || rd_im !== ei) begin
                n_fail++;
                $display("FAIL %s: valid=%0b re=%h im=%h expected valid=%0b re=%h im=%h",
                         tg, rd_valid, rd_re, rd_im, v, er, ei);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 4; c++) begin mh_re[r][c] = 0; mh_im[r][c] = 0; end
            my_re[r] = 0; my_im[r] = 0; mk_re[r] = 0; mk_im[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rd_valid !== 1'b0 || rd_re !== '0 || rd_im !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b re=%h expected valid=0 re=0", rd_valid, rd_re);
        end
        rd(0, 0, 3, 0, "R1 row after reset");
        rd(1, 1, 0, 1, "R1 vector after reset");
        rd(2, 1, 0, 0, "R1 constants after reset");

        // load everything; the idle read side also checks R8 hold
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 4; c++)
                wr(0, r, c, pv(0, r, c), -3 * pv(0, r, c), "R8 hold during load");
        for (int r = 0; r < 8; r++) begin
            wr(1, r, (r % 3) + 1, pv(1, r, 0), -pv(1, r, 0), "R6 vector write col ignored");
            wr(2, r, 0, pv(2, r, 0), 5 * pv(2, r, 0), "R6 constant write");
        end

        for (int r = 0; r < 8; r++) rd(0, 0, r, 0, "R2 row read");
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, c, 0, "R3 column upper half");
            rd(0, 1, c, 1, "R3 column lower half");
        end
        rd(1, 0, 9, 0, "R4 vector upper, mode/idx ignored");
        rd(1, 1, 2, 1, "R4 vector lower");
        rd(2, 0, 15, 1, "R4 constants lower, mode/idx ignored");
        rd(2, 1, 0, 0, "R4 constants upper");

        rd(0, 0, 8, 0, "R5 row index 8");
        rd(0, 0, 15, 1, "R5 row index 15");
        rd(0, 1, 4, 0, "R5 column index 4");
        rd(0, 1, 9, 1, "R5 column index 9");
        rd(3, 0, 1, 0, "R9 target none");

        wr(0, 9, 0, 111, 222, "R6 bad row write");
        wr(0, 0, 5, 333, 444, "R6 bad column write");
        wr(1, 8, 0, 555, 666, "R6 bad vector write");
        wr(3, 0, 0, 777, 888, "R6 target none write");
        rd(0, 0, 0, 0, "R6 row 0 untouched");
        rd(0, 1, 0, 0, "R6 column 0 untouched");
        rd(1, 1, 0, 1, "R6 vector untouched");
        rd(2, 1, 0, 0, "R6 constants untouched");

        cyc(1, 0, 2, 1, 9999, -9999, 1, 0, 0, 2, 0, "R7 collision returns old");
        rd(0, 0, 2, 0, "R7 next read returns new");
        cyc(1, 1, 6, 0, 4321, 1234, 1, 1, 1, 0, 1, "R7 vector collision returns old");
        rd(1, 1, 0, 1, "R7 vector next read new");

        rd(0, 1, 3, 1, "R3 column before gap");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1, "R8 idle hold");
        cyc(0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 0, "R8 idle hold second");
        rd(0, 0, 7, 0, "R2 row after gap");

        while (q_v.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule